// File: doc/BRIEF.md
# Persistent Set/Reset Latch Bank

This block holds a bank of latch bits (eight by default). Each bit has its own set request and reset request. The requests take effect only on a processing-interval tick. On that tick a bit with a reset request goes to 0, even when its set request is also present. A bit with only a set request goes to 1. A bit with neither request keeps its value. Between ticks the requests are ignored, so a reconfiguration of whatever produces them cannot disturb the stored states.

Every tick that changes at least one bit schedules one write of the whole bank, packed as one byte, to a nonvolatile store. The store is modelled as a simple port with a write strobe and a busy input. While the store reports busy, the pending write waits. Changes that arrive in the meantime fold into it, so the write that finally goes out carries the newest state.

At power-up the bank first reads its saved byte back from the store. Until that read completes, the latch outputs are held at 0 and ticks are ignored. A saturating counter of issued writes, together with a programmable warning threshold, supports wear monitoring of the store.

Top module: `nvLatchBank`

## Requirements
- R1: On a tick (`evalStrobe` high after restore), a bit with its set request high and its reset request low reads 1 on `latchQ` in the cycle after the tick.
- R2: On a tick, a bit with its reset request high reads 0 in the cycle after the tick, whatever its set request.
- R3: Without a tick, `setReq` and `rstReq` have no effect: `latchQ` keeps its value, and no write is issued.
- R4: After reset, `nvRdReq` is high and `restoreDone` is low. In the cycle after `nvRdValid` is sampled high, `latchQ` equals `nvRdData` (bit 0 is latch 1), `restoreDone` is 1 and `nvRdReq` is 0. The restore itself issues no write.
- R5: While `restoreDone` is low, `latchQ` is all zero, and ticks do not change the bank.
- R6: A tick that changes no bit issues no write. A tick that changes any bit produces a one-cycle `nvWrEn` pulse one cycle after `latchQ` updates, with `nvWrData` equal to the whole bank (bit i holds latch i+1).
- R7: While `nvBusy` is sampled high, no write is issued. Changes made meanwhile merge into one write, issued the cycle after `nvBusy` is sampled low, that carries the latest bank value.
- R8: `writeCount` rises by one in the same cycle as each `nvWrEn` pulse. It saturates at its all-ones value and clears on reset.
- R9: `wearWarn` is high exactly when `writeCount` is greater than or equal to `wearThreshold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (models power loss) |
| evalStrobe | input | 1 | Processing-interval tick |
| setReq | input | NUM_LATCH | Set requests, bit i for latch i+1 |
| rstReq | input | NUM_LATCH | Reset requests, bit i for latch i+1 |
| nvRdReq | output | 1 | Restore read request |
| nvRdValid | input | 1 | Restore data valid |
| nvRdData | input | NUM_LATCH | Saved bank byte |
| nvBusy | input | 1 | Store cannot accept a write |
| nvWrEn | output | 1 | Write strobe, one cycle per write |
| nvWrData | output | NUM_LATCH | Packed bank value to store |
| wearThreshold | input | CNT_W | Wear warning threshold |
| latchQ | output | NUM_LATCH | Latch states, zero until restore completes |
| restoreDone | output | 1 | Restore read has completed |
| writeCount | output | CNT_W | Saturating count of issued writes |
| wearWarn | output | 1 | Write count has reached the threshold |

## Verification
A tick moves `latchQ` one cycle later. Any resulting write strobe, with its data and the incremented count, appears one cycle after that. A restore read moves `latchQ` and `restoreDone` one cycle after `nvRdValid`. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sits exactly one rising edge after its cause. The busy and no-change scenarios confirm the absence of a strobe over several consecutive sampled cycles. Because the store model keeps the last written byte, a mid-run reset shows that the final coalesced value is the one that comes back.

// File: rtl/nvLatchBank_pkg.sv
package nvLatchBank_pkg;
  typedef enum logic {
    S_RESTORE = 1'b0,
    S_RUN     = 1'b1
  } nvState_t;

  typedef struct packed {
    logic loadRestore;
    logic evalEn;
    logic issueWrite;
  } nvStrobes_t;
endpackage

// File: rtl/nvLatchCtrl.sv
module nvLatchCtrl
  import nvLatchBank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evalStrobe,
  input  logic       nvRdValid,
  input  logic       nvBusy,
  input  logic       pending,
  output nvStrobes_t strobes,
  output logic       nvRdReq,
  output logic       restoreDone
);
  nvState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_RESTORE;
    end else if (state == S_RESTORE && nvRdValid) begin
      state <= S_RUN;
    end
  end

  always_comb begin
    strobes.loadRestore = (state == S_RESTORE) && nvRdValid;
    strobes.evalEn      = (state == S_RUN) && evalStrobe;
    strobes.issueWrite  = (state == S_RUN) && pending && !nvBusy;
    nvRdReq             = (state == S_RESTORE);
    restoreDone         = (state == S_RUN);
  end
endmodule

// File: rtl/nvLatchDatapath.sv
module nvLatchDatapath
  import nvLatchBank_pkg::*;
#(
  parameter int NUM_LATCH = 8,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nvStrobes_t           strobes,
  input  logic [NUM_LATCH-1:0] setReq,
  input  logic [NUM_LATCH-1:0] rstReq,
  input  logic [NUM_LATCH-1:0] nvRdData,
  input  logic [CNT_W-1:0]     wearThreshold,
  input  logic                 restoreDone,
  output logic                 pending,
  output logic                 nvWrEn,
  output logic [NUM_LATCH-1:0] nvWrData,
  output logic [NUM_LATCH-1:0] latchQ,
  output logic [CNT_W-1:0]     writeCount,
  output logic                 wearWarn
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_LATCH-1:0] bank;
  logic [NUM_LATCH-1:0] nextBank;
  logic                 changed;

  // Per-bit evaluation: reset dominates set.
  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_bit
    always_comb begin
      if (rstReq[i])      nextBank[i] = 1'b0;
      else if (setReq[i]) nextBank[i] = 1'b1;
      else                nextBank[i] = bank[i];
    end
  end

  assign changed = strobes.evalEn && (nextBank != bank);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank <= '0;
    end else if (strobes.loadRestore) begin
      bank <= nvRdData;
    end else if (changed) begin
      bank <= nextBank;
    end
  end

  // Pending write: a change made at the same edge as an issue keeps it armed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (changed) begin
      pending <= 1'b1;
    end else if (strobes.issueWrite) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvWrEn   <= 1'b0;
      nvWrData <= '0;
    end else begin
      nvWrEn <= strobes.issueWrite;
      if (strobes.issueWrite) nvWrData <= bank;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeCount <= '0;
    end else if (strobes.issueWrite && writeCount != CNT_MAX) begin
      writeCount <= writeCount + 1'b1;
    end
  end

  assign wearWarn = (writeCount >= wearThreshold);
  assign latchQ   = bank & {NUM_LATCH{restoreDone}};
endmodule

// File: rtl/nvLatchBank.sv
module nvLatchBank
  import nvLatchBank_pkg::*;
#(
  parameter int NUM_LATCH = 8,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalStrobe,
  input  logic [NUM_LATCH-1:0] setReq,
  input  logic [NUM_LATCH-1:0] rstReq,
  output logic                 nvRdReq,
  input  logic                 nvRdValid,
  input  logic [NUM_LATCH-1:0] nvRdData,
  input  logic                 nvBusy,
  output logic                 nvWrEn,
  output logic [NUM_LATCH-1:0] nvWrData,
  input  logic [CNT_W-1:0]     wearThreshold,
  output logic [NUM_LATCH-1:0] latchQ,
  output logic                 restoreDone,
  output logic [CNT_W-1:0]     writeCount,
  output logic                 wearWarn
);
  nvStrobes_t strobes;
  logic       pending;

  nvLatchCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evalStrobe  (evalStrobe),
    .nvRdValid   (nvRdValid),
    .nvBusy      (nvBusy),
    .pending     (pending),
    .strobes     (strobes),
    .nvRdReq     (nvRdReq),
    .restoreDone (restoreDone)
  );

  nvLatchDatapath #(
    .NUM_LATCH (NUM_LATCH),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .setReq        (setReq),
    .rstReq        (rstReq),
    .nvRdData      (nvRdData),
    .wearThreshold (wearThreshold),
    .restoreDone   (restoreDone),
    .pending       (pending),
    .nvWrEn        (nvWrEn),
    .nvWrData      (nvWrData),
    .latchQ        (latchQ),
    .writeCount    (writeCount),
    .wearWarn      (wearWarn)
  );
endmodule

// File: rtl/nvLatchBank_chk.sv
module nvLatchBank_chk #(
  parameter int NUM_LATCH = 8,
  parameter int CNT_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evalStrobe,
  input logic [NUM_LATCH-1:0] setReq,
  input logic [NUM_LATCH-1:0] rstReq,
  input logic                 nvRdReq,
  input logic                 nvBusy,
  input logic                 nvWrEn,
  input logic [NUM_LATCH-1:0] latchQ,
  input logic                 restoreDone,
  input logic [CNT_W-1:0]     writeCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    (evalStrobe && restoreDone) |=>
      ((latchQ & $past(setReq & ~rstReq)) == $past(setReq & ~rstReq)));

  a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evalStrobe && restoreDone) |=> ((latchQ & $past(rstReq)) == '0));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!evalStrobe && restoreDone) |=> $stable(latchQ));

  a_r4_no_read_after_restore: assert property (@(posedge clk) disable iff (!rstN)
    restoreDone |-> !nvRdReq);

  a_r5_outputs_off: assert property (@(posedge clk) disable iff (!rstN)
    !restoreDone |-> (latchQ == '0));

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    nvBusy |=> !nvWrEn);

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (nvWrEn && $past(rstN) && $past(writeCount) != CNT_MAX) |->
      (writeCount == $past(writeCount) + 1'b1));
endmodule

bind nvLatchBank nvLatchBank_chk #(
  .NUM_LATCH (NUM_LATCH),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .evalStrobe  (evalStrobe),
  .setReq      (setReq),
  .rstReq      (rstReq),
  .nvRdReq     (nvRdReq),
  .nvBusy      (nvBusy),
  .nvWrEn      (nvWrEn),
  .latchQ      (latchQ),
  .restoreDone (restoreDone),
  .writeCount  (writeCount)
);

// File: tb/nvLatchBank_bench.sv
`timescale 1ns/1ps
module nvLatchBank_bench;
  localparam int N  = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evalStrobe = 1'b0;
  logic [N-1:0]  setReq = '0;
  logic [N-1:0]  rstReq = '0;
  logic          nvRdReq;
  logic          nvRdValid = 1'b0;
  logic [N-1:0]  nvRdData = '0;
  logic          nvBusy = 1'b0;
  logic          nvWrEn;
  logic [N-1:0]  nvWrData;
  logic [CW-1:0] wearThreshold = 4'd4;
  logic [N-1:0]  latchQ;
  logic          restoreDone;
  logic [CW-1:0] writeCount;
  logic          wearWarn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] nvMem = '0;
  logic [N-1:0] model = '0;
  int expCount = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (nvWrEn) nvMem <= nvWrData;

  nvLatchBank #(.NUM_LATCH(N), .CNT_W(CW)) u_nvLatchBank (
    .clk(clk), .rstN(rstN), .evalStrobe(evalStrobe), .setReq(setReq),
    .rstReq(rstReq), .nvRdReq(nvRdReq), .nvRdValid(nvRdValid),
    .nvRdData(nvRdData), .nvBusy(nvBusy), .nvWrEn(nvWrEn),
    .nvWrData(nvWrData), .wearThreshold(wearThreshold), .latchQ(latchQ),
    .restoreDone(restoreDone), .writeCount(writeCount), .wearWarn(wearWarn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Apply one tick; returns after latchQ has updated.
  task automatic evalTick(input logic [N-1:0] s, input logic [N-1:0] r);
    setReq = s; rstReq = r; evalStrobe = 1'b1;
    tick();
    evalStrobe = 1'b0; setReq = '0; rstReq = '0;
    if (restoreDone) model = (model | s) & ~r;
  endtask

  task automatic expectWrite(input string req);
    tick();
    if (expCount < 15) expCount++;
    chk({req, " wrEn"}, nvWrEn, 1);
    chk({req, " wrData"}, nvWrData, model);
    chk({req, " count"}, writeCount, expCount);
    tick();
    chk({req, " single pulse"}, nvWrEn, 0);
  endtask

  task automatic doRestore(input logic [N-1:0] d);
    nvRdData = d; nvRdValid = 1'b1;
    tick();
    nvRdValid = 1'b0;
    model = d;
  endtask

  task automatic testRestore();
    tick();
    chk("R4 reset rdReq", nvRdReq, 1);
    chk("R4 reset restoreDone", restoreDone, 0);
    chk("R5 reset latchQ", latchQ, 0);
    evalTick(8'hFF, 8'h00);
    tick();
    chk("R5 tick ignored before restore", latchQ, 0);
    doRestore(8'hA5);
    chk("R4 restored value", latchQ, 8'hA5);
    chk("R4 restoreDone", restoreDone, 1);
    chk("R4 rdReq dropped", nvRdReq, 0);
    tick();
    chk("R4 restore issues no write", nvWrEn, 0);
  endtask

  task automatic testSetReset();
    evalTick(8'h0A, 8'h00);
    chk("R1 set bits", latchQ, 8'hAF);
    expectWrite("R6 set write");
    evalTick(8'h81, 8'h83);
    chk("R2 reset priority", latchQ, 8'h2C);
    expectWrite("R6 reset write");
  endtask

  task automatic testNoChange();
    evalTick(8'h0C, 8'h10);
    chk("R6 unchanged latchQ", latchQ, 8'h2C);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 no write without change", nvWrEn, 0);
    end
    chk("R6 count unchanged", writeCount, expCount);
  endtask

  task automatic testNoTick();
    setReq = 8'hFF; rstReq = 8'h00;
    for (int i = 0; i < 4; i++) tick();
    chk("R3 set ignored without tick", latchQ, 8'h2C);
    setReq = 8'h00; rstReq = 8'hFF;
    tick();
    chk("R3 reset ignored without tick", latchQ, 8'h2C);
    chk("R3 no write without tick", nvWrEn, 0);
    setReq = '0; rstReq = '0;
  endtask

  task automatic testBusy();
    nvBusy = 1'b1;
    evalTick(8'h01, 8'h00);
    chk("R1 set under busy", latchQ, 8'h2D);
    tick();
    chk("R7 held while busy", nvWrEn, 0);
    evalTick(8'h00, 8'h04);
    chk("R2 reset under busy", latchQ, 8'h29);
    tick();
    chk("R7 still held", nvWrEn, 0);
    nvBusy = 1'b0;
    expectWrite("R7 coalesced write");
    tick();
    chk("R7 only one write", nvWrEn, 0);
  endtask

  task automatic testWear();
    chk("R9 below threshold", wearWarn, 0);
    evalTick(8'h40, 8'h00);
    expectWrite("R8 wear write");
    chk("R9 at threshold", wearWarn, 1);
    for (int i = 0; i < 14; i++) begin
      if (model[6]) evalTick(8'h00, 8'h40);
      else          evalTick(8'h40, 8'h00);
      expectWrite("R8 saturating write");
    end
    chk("R8 saturated", writeCount, 15);
    chk("R9 above threshold", wearWarn, 1);
  endtask

  task automatic testPowerLoss();
    logic [N-1:0] saved;
    evalTick(8'h10, 8'h00);
    expectWrite("R6 pre power loss");
    saved = nvMem;
    chk("R6 store holds bank", saved, model);
    rstN = 1'b0;
    tick();
    chk("R5 outputs off in power loss", latchQ, 0);
    chk("R8 count cleared", writeCount, 0);
    rstN = 1'b1;
    tick();
    chk("R4 rdReq after power up", nvRdReq, 1);
    doRestore(saved);
    chk("R4 state survives power loss", latchQ, saved);
  endtask

  initial begin
    #(4 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    testRestore();
    testSetReset();
    testNoChange();
    testNoTick();
    testBusy();
    testWear();
    testPowerLoss();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule